// File: doc/BRIEF.md
# Rolling-Counter Alignment Hunter

This block watches the single serial lane that carries a two-bit rolling frame counter and finds where that counter sits inside each twelve-bit pixel word. It collects twelve valid bits into a window and reads the window as six adjacent two-bit candidate pairs. The first window after a search starts is only stored. Each later window is compared pair by pair against the stored value plus one, modulo four, and every candidate that fails is struck off for good.

All six candidates are tested in the same cycle. When exactly one candidate is left, the block raises a single-cycle found pulse and presents the pair index as an offset from 0 to 5. The lock tracker downstream decides what to do with that offset. If all candidates fail, the hunt begins again with a fresh snapshot. After a find, the block stays quiet until the tracker asks for a new search. Because payload data can imitate the counter, the length of a search depends on the data.

Top module: `inc_align_hunter`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `found_o` is 0 and `offset_o` is 0. Reset also restarts window framing, and the search is active.
- R2: A window is complete after twelve cycles with `bit_vld_i` high. Cycles with `bit_vld_i` low are ignored. The first bit received becomes window bit 11. Pair k occupies window bits [2k+1:2k], with the earlier bit as the MSB.
- R3: The first complete window after reset or after a restart is only stored, and `found_o` stays 0 at its end.
- R4: A live candidate survives a compare only if its new pair equals its previously observed value plus one, modulo four, so 3 is followed by 0. After every compare, the stored value is replaced by the new pair.
- R5: A candidate that has been struck off stays struck off until the next snapshot, even if its later pairs increment correctly.
- R6: When exactly one candidate survives a compare, `found_o` is high for exactly one cycle, the cycle after the window's twelfth bit is clocked in. In that cycle `offset_o` equals the surviving k. `offset_o` keeps that value until the next find or reset.
- R7: When two or more candidates survive, there is no pulse and comparing continues on the next window.
- R8: When no candidate survives, there is no pulse and the next complete window is a fresh snapshot.
- R9: After a find, further windows produce no pulse until `hunt_start_i` is pulsed. A pulse of `hunt_start_i` discards any partial window, restarts framing at the next valid bit, and makes the next window a snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hunt_start_i | input | 1 | Pulse that restarts framing and the search |
| bit_vld_i | input | 1 | Qualifies `bit_i` for this cycle |
| bit_i | input | 1 | Serial bit from the counter-carrying lane |
| found_o | output | 1 | One-cycle pulse when a single candidate remains |
| offset_o | output | 3 | Index (0 to 5) of the surviving pair, held |

## Verification
The only timed result is the found decision. It is registered once, so it appears in the cycle after the twelfth valid bit of a compare window reaches the clock edge. The bench drives bits on falling edges and samples `found_o` and `offset_o` at the falling edge right after that twelfth rising edge. It samples again one cycle later to confirm the pulse is one cycle wide. A window that ends with no find is checked at the same point, so an early or late pulse shows up as a mismatch. Restart and reset are checked by the framing of the windows sent afterwards.

// File: rtl/inc_hunt_pkg.sv
package inc_hunt_pkg;

    localparam int PAIR_W = 2;

    typedef logic [PAIR_W-1:0] pair_t;

    typedef enum logic [1:0] {
        HUNT_SNAP = 2'd0,
        HUNT_CMP  = 2'd1,
        HUNT_IDLE = 2'd2
    } hunt_state_e;

    typedef struct packed {
        pair_t prev;
        logic  live;
    } cand_t;

    function automatic pair_t pair_succ(input pair_t v);
        return v + pair_t'(1);
    endfunction

endpackage

// File: rtl/inc_window_shift.sv
module inc_window_shift #(
    parameter int WIN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             bit_vld,
    input  logic             bit_in,
    output logic             win_vld,
    output logic [WIN_W-1:0] win_data
);
    localparam int CNT_W = $clog2(WIN_W);

    logic [WIN_W-2:0] sh_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last_bit;

    assign last_bit = (cnt_q == CNT_W'(WIN_W - 1));
    assign win_vld  = bit_vld && !clr && last_bit;
    assign win_data = {sh_q, bit_in};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (bit_vld) begin
            sh_q  <= {sh_q[WIN_W-3:0], bit_in};
            cnt_q <= last_bit ? '0 : cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/inc_pair_cell.sv
module inc_pair_cell
    import inc_hunt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  snap,
    input  logic  cmp,
    input  pair_t obs,
    output logic  match_o,
    output logic  live_o
);
    cand_t cand_q;

    assign match_o = cand_q.live && (obs == pair_succ(cand_q.prev));
    assign live_o  = cand_q.live;

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q <= '0;
        end else if (snap) begin
            cand_q <= '{prev: obs, live: 1'b1};
        end else if (cmp) begin
            cand_q <= '{prev: obs, live: match_o};
        end
    end
endmodule

// File: rtl/inc_survivor_pick.sv
module inc_survivor_pick #(
    parameter int PAIRS = 6
) (
    input  logic [PAIRS-1:0]         hits,
    output logic                     one_o,
    output logic                     none_o,
    output logic [$clog2(PAIRS)-1:0] idx_o
);
    localparam int OFF_W = $clog2(PAIRS);

    assign one_o  = $onehot(hits);
    assign none_o = (hits == '0);

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < PAIRS; i++) begin
            if (hits[i]) idx_o = OFF_W'(i);
        end
    end
endmodule

// File: rtl/inc_align_hunter.sv
module inc_align_hunter
    import inc_hunt_pkg::*;
#(
    parameter int PAIRS = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     hunt_start_i,
    input  logic                     bit_vld_i,
    input  logic                     bit_i,
    output logic                     found_o,
    output logic [$clog2(PAIRS)-1:0] offset_o
);
    localparam int WIN_W = PAIRS * PAIR_W;
    localparam int OFF_W = $clog2(PAIRS);

    hunt_state_e      state_q;
    logic             win_vld;
    logic [WIN_W-1:0] win_data;
    logic             snap_w;
    logic             cmp_w;
    logic [PAIRS-1:0] hits;
    logic [PAIRS-1:0] live;
    logic             one_left;
    logic             none_left;
    logic [OFF_W-1:0] pick_idx;

    inc_window_shift #(.WIN_W(WIN_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .clr      (hunt_start_i),
        .bit_vld  (bit_vld_i),
        .bit_in   (bit_i),
        .win_vld  (win_vld),
        .win_data (win_data)
    );

    assign snap_w = win_vld && (state_q == HUNT_SNAP);
    assign cmp_w  = win_vld && (state_q == HUNT_CMP);

    for (genvar k = 0; k < PAIRS; k++) begin : g_cell
        inc_pair_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .snap    (snap_w),
            .cmp     (cmp_w),
            .obs     (win_data[k*PAIR_W +: PAIR_W]),
            .match_o (hits[k]),
            .live_o  (live[k])
        );
    end

    inc_survivor_pick #(.PAIRS(PAIRS)) u_pick (
        .hits   (hits),
        .one_o  (one_left),
        .none_o (none_left),
        .idx_o  (pick_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= HUNT_SNAP;
            found_o  <= 1'b0;
            offset_o <= '0;
        end else begin
            found_o <= 1'b0;
            if (hunt_start_i) begin
                state_q <= HUNT_SNAP;
            end else if (snap_w) begin
                state_q <= HUNT_CMP;
            end else if (cmp_w) begin
                if (one_left) begin
                    found_o  <= 1'b1;
                    offset_o <= pick_idx;
                    state_q  <= HUNT_IDLE;
                end else if (none_left) begin
                    state_q <= HUNT_SNAP;
                end
            end
        end
    end
endmodule

// File: rtl/inc_align_hunter_chk.sv
module inc_align_hunter_chk
    import inc_hunt_pkg::*;
#(
    parameter int PAIRS = 6
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     hunt_start_i,
    input logic                     found_o,
    input logic [$clog2(PAIRS)-1:0] offset_o,
    input hunt_state_e              state_q,
    input logic                     snap_w,
    input logic [PAIRS-1:0]         live
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!found_o && offset_o == '0));

    assert_snap_no_find_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == HUNT_SNAP) |=> !found_o);

    assert_struck_stays_R5: assert property (@(posedge clk) disable iff (rst)
        !snap_w |=> ((live & ~$past(live)) == '0));

    assert_one_cycle_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        found_o |=> !found_o);

    assert_offset_range_R6: assert property (@(posedge clk) disable iff (rst)
        found_o |-> (int'(offset_o) < PAIRS));

    assert_idle_silent_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == HUNT_IDLE && !hunt_start_i) |=> !found_o);
endmodule

bind inc_align_hunter inc_align_hunter_chk #(.PAIRS(PAIRS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .hunt_start_i (hunt_start_i),
    .found_o      (found_o),
    .offset_o     (offset_o),
    .state_q      (state_q),
    .snap_w       (snap_w),
    .live         (live)
);

// File: tb/test_inc_align_hunter.sv
module test_inc_align_hunter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hunt_start_i = 1'b0;
    logic       bit_vld_i = 1'b0;
    logic       bit_i = 1'b0;
    logic       found_o;
    logic [2:0] offset_o;

    int n_chk = 0;
    int n_err = 0;

    inc_align_hunter #(.PAIRS(6)) i_inc_align_hunter (
        .clk          (clk),
        .rst          (rst),
        .hunt_start_i (hunt_start_i),
        .bit_vld_i    (bit_vld_i),
        .bit_i        (bit_i),
        .found_o      (found_o),
        .offset_o     (offset_o)
    );

    always #5 clk = ~clk;

    // {hunt before window, window[11:0], expected found, expected offset}
    localparam int NVEC = 10;
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 12'h010, 1'b0, 3'd0},  // R3 snapshot, p2=1
        {1'b0, 12'h020, 1'b1, 3'd2},  // R6 lone survivor p2
        {1'b0, 12'h030, 1'b0, 3'd2},  // R9 idle: would match, ignored
        {1'b1, 12'hC01, 1'b0, 3'd2},  // R9 restart, snapshot p5=3 p0=1
        {1'b0, 12'h2AA, 1'b0, 3'd2},  // R7 p5 wraps 3->0, p0 1->2 survive
        {1'b0, 12'h7FC, 1'b1, 3'd5},  // R5 struck pairs increment, R4 p5
        {1'b1, 12'h000, 1'b0, 3'd5},  // snapshot all zero
        {1'b0, 12'h000, 1'b0, 3'd5},  // R8 all struck
        {1'b0, 12'h001, 1'b0, 3'd5},  // R8 fresh snapshot, no find
        {1'b0, 12'h002, 1'b1, 3'd0}   // R4 p0 1->2
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input bit gap);
        @(negedge clk);
        bit_vld_i = 1'b1;
        bit_i     = b;
        @(posedge clk);
        if (gap) begin
            @(negedge clk);
            bit_vld_i = 1'b0;
            bit_i     = ~b;
            @(posedge clk);
        end
    endtask

    // ends at the falling edge after the twelfth valid bit was clocked
    task automatic send_win(input logic [11:0] w, input bit gap);
        for (int i = 11; i >= 0; i--) send_bit(w[i], gap && i != 0);
        @(negedge clk);
        bit_vld_i = 1'b0;
    endtask

    task automatic pulse_hunt();
        @(negedge clk);
        hunt_start_i = 1'b1;
        bit_vld_i    = 1'b1;
        bit_i        = 1'b1;
        @(posedge clk);
        @(negedge clk);
        hunt_start_i = 1'b0;
        bit_vld_i    = 1'b0;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 found in reset", int'(found_o), 0);
        check("R1 offset in reset", int'(offset_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 found after reset", int'(found_o), 0);

        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][16]) pulse_hunt();
            send_win(VEC[v][15:4], 1'b0);
            check($sformatf("R6/R7 found vec %0d", v), int'(found_o), int'(VEC[v][3]));
            check($sformatf("R6 offset vec %0d", v), int'(offset_o), int'(VEC[v][2:0]));
            if (VEC[v][3]) begin
                @(negedge clk);
                check($sformatf("R6 pulse width vec %0d", v), int'(found_o), 0);
            end
        end

        // R9/R2: partial window discarded by restart, gapped bits
        pulse_hunt();
        for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0);
        pulse_hunt();
        send_win(12'h080, 1'b1);
        check("R3 snapshot after restart", int'(found_o), 0);
        send_win(12'h0C0, 1'b1);
        check("R2 gapped window found", int'(found_o), 1);
        check("R2 gapped window offset", int'(offset_o), 3);

        // R1: reset mid-window restarts framing and search
        pulse_hunt();
        for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0);
        @(negedge clk);
        bit_vld_i = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 offset after mid reset", int'(offset_o), 0);
        send_win(12'h100, 1'b0);
        check("R1 first window after reset is snapshot", int'(found_o), 0);
        send_win(12'h200, 1'b0);
        check("R1 framing after reset found", int'(found_o), 1);
        check("R1 framing after reset offset", int'(offset_o), 4);

        report();
    end
endmodule